// File: doc/BRIEF.md
# Panel Power-Up Init Sequencer

This block takes a display panel that is configured over a 9-bit serial link from cold reset to its operating state. A `start` pulse launches the sequence. The block first drives the panel's active-low reset pin through a timed high–low–high pulse and lets the panel settle. It then asks the serial engine to read a one-byte panel ID. That byte selects one of two built-in command tables. The 8-entry short table is used when the ID is 0x80. The 22-entry long table is used for any other ID.

Each table entry is sent as one command word followed by its parameter words. After the entry's last word, the block idles for that entry's own delay in milliseconds. When the table is finished, the block sends display-on (0x29), waits a fixed gap, and then sends sleep-out (0x11). All waits are counted on a one-cycle millisecond clock-enable, `ms_tick`. The serial bit timing lives in the engine, which sits on the far side of a request/acknowledge port.

States:
- S_IDLE: waits for `start`.
- S_RHI, S_RLO, S_RWT: the reset pin high phase, low phase and settle wait.
- S_ID: the ID read.
- S_CMD, S_PRM: command word and parameter words.
- S_DLY: post-entry delay.
- S_ON, S_GAP, S_OUT: display-on, gap, sleep-out.
- S_DONE: one-cycle completion.

Transitions:
- S_IDLE→S_RHI on `start`, or S_IDLE→S_ID when the pin is built as absent.
- S_RHI→S_RLO→S_RWT→S_ID, each when its timer expires.
- S_ID→S_CMD when the ID read is acknowledged without error. S_ID→S_IDLE on an error.
- S_CMD→S_PRM when the entry has parameters.
- S_PRM→S_PRM while parameters remain.
- At the end of an entry: S_CMD or S_PRM → S_DLY if the delay is non-zero. Otherwise → S_CMD for the next entry, or → S_ON after the last entry.
- S_DLY→S_CMD or S_ON when the timer expires.
- S_ON→S_GAP on acknowledge. S_GAP→S_OUT when the timer expires. S_OUT→S_DONE on acknowledge. S_DONE→S_IDLE.

Top module: `panel_boot_seq`

## Requirements
- R1: While `rst_n` is low and after it rises with no start, `busy`, `done`, `fail` and `bus_req` are 0 and `panel_rst_n` is 0.
- R2: `start` seen in S_IDLE raises `busy` on the next cycle. `start` while busy has no effect on the sequence.
- R3: The reset pin is high for RST_HI_MS (100) ticks, low for RST_LO_MS (40) ticks, then high for RST_SETTLE_MS (100) ticks before the first request. No request is made while the pin is low.
- R4: The first request is an ID read: `bus_rd`=1 with `bus_word`=0x004. A returned byte of 0x80 selects the short table; any other byte selects the long table.
- R5: A command word has bit 8 = 0 and the command in bits 7:0. A parameter word has bit 8 = 1. Parameter k (counting from 0) of an entry equals cmd XOR (k·0x1D mod 256), with two exceptions: long entry 0 carries 0xFF, 0x98, 0x06, and the last long entry carries 0x00.
- R6: The short table, as command/parameter-count pairs in order: 36/1, 3A/1, B6/4, C5/2, E0/16, E1/16, B0/1, B4/1. The long table: FF/3, BA/1, BC/21, BD/8, BE/9, C7/1, ED/3, C0/3, FC/1, B6/1, DF/6, F3/1, B4/3, F7/1, B1/3, F2/4, C1/4, 36/1, 3A/1, E0/16, E1/16, 35/1.
- R7: After an entry's last word, the block waits exactly that entry's delay in ticks before its next request. Short E1 has 20, short B4 has 100, and every other entry has 0. A zero delay adds no idle tick.
- R8: An acknowledge with `bus_err` on any word of a table entry skips that entry's remaining parameters. The entry's delay is still applied, and the next entry follows.
- R9: After the table, the block sends 0x29, waits ON_GAP_MS (100) ticks, then sends 0x11. Both have no parameters.
- R10: An error on the ID read sets `fail`, drops `busy`, makes no further request and gives no `done`. `fail` clears at the next accepted `start`.
- R11: `busy` stays high until 0x11 is acknowledged. `done` is then high for exactly one cycle, with `busy` low.
- R12: With HAS_RST_PIN=0, `panel_rst_n` stays high and the ID read is requested with no reset waits.
- R13: Once `bus_req` is raised, it stays high with `bus_word` and `bus_rd` unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond enable |
| start | input | 1 | Starts the sequence when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | ID read failed; cleared at the next start |
| panel_rst_n | output | 1 | Active-low panel reset pin |
| bus_req | output | 1 | Request to the serial engine |
| bus_rd | output | 1 | Request is the ID read |
| bus_word | output | 9 | Word to send; bit 8 is the parameter flag |
| bus_ack | input | 1 | Engine finished the current word |
| bus_err | input | 1 | The acknowledged word failed |
| bus_rdata | input | 8 | ID byte, valid with the acknowledge of the read |

## Verification
A wrong entry index or parameter counter shows up as a wrong word at the very next acknowledge. The sent stream is therefore compared word by word, and the first diverging word pinpoints the fault. A timer loaded with the wrong value, or a wait that is wrongly skipped, shows up as a wrong count of ticks consumed between two specific words, or inside one reset-pin phase. These counts are compared for each word gap. A wrong table select, or a wrong error path, changes the word count and the `fail`/`done` outcome by the end of the run.

// File: rtl/panel_boot_pkg.sv
package panel_boot_pkg;
    localparam int ENT_W = 5;
    localparam int CNT_W = 5;
    localparam int MSD_W = 7;
    localparam int N_SHORT = 8;
    localparam int N_LONG = 22;
    localparam logic [7:0] ID_SHORT = 8'h80;
    localparam logic [7:0] CMD_RDID = 8'h04;
    localparam logic [7:0] CMD_DISP_ON = 8'h29;
    localparam logic [7:0] CMD_WAKE = 8'h11;

    typedef enum logic [3:0] {
        S_IDLE, S_RHI, S_RLO, S_RWT, S_ID, S_CMD, S_PRM,
        S_DLY, S_ON, S_GAP, S_OUT, S_DONE
    } boot_state_e;

    typedef struct packed {
        logic [7:0]       cmd;
        logic [CNT_W-1:0] cnt;
        logic [MSD_W-1:0] dly;
    } entry_t;

    function automatic entry_t mk(input logic [7:0] c, input int n, input int d);
        entry_t e;
        e.cmd = c;
        e.cnt = CNT_W'(n);
        e.dly = MSD_W'(d);
        return e;
    endfunction
endpackage

// File: rtl/panel_cmd_rom.sv
module panel_cmd_rom
    import panel_boot_pkg::*;
(
    input  logic             use_short,
    input  logic [ENT_W-1:0] ent,
    input  logic [CNT_W-1:0] pidx,
    output entry_t           entry,
    output logic [7:0]       param,
    output logic             last_ent
);
    entry_t short_e, long_e;

    always_comb begin
        unique case (ent)
            5'd0:    short_e = mk(8'h36, 1, 0);
            5'd1:    short_e = mk(8'h3A, 1, 0);
            5'd2:    short_e = mk(8'hB6, 4, 0);
            5'd3:    short_e = mk(8'hC5, 2, 0);
            5'd4:    short_e = mk(8'hE0, 16, 0);
            5'd5:    short_e = mk(8'hE1, 16, 20);
            5'd6:    short_e = mk(8'hB0, 1, 0);
            5'd7:    short_e = mk(8'hB4, 1, 100);
            default: short_e = mk(8'h00, 0, 0);
        endcase
    end

    always_comb begin
        unique case (ent)
            5'd0:    long_e = mk(8'hFF, 3, 0);
            5'd1:    long_e = mk(8'hBA, 1, 0);
            5'd2:    long_e = mk(8'hBC, 21, 0);
            5'd3:    long_e = mk(8'hBD, 8, 0);
            5'd4:    long_e = mk(8'hBE, 9, 0);
            5'd5:    long_e = mk(8'hC7, 1, 0);
            5'd6:    long_e = mk(8'hED, 3, 0);
            5'd7:    long_e = mk(8'hC0, 3, 0);
            5'd8:    long_e = mk(8'hFC, 1, 0);
            5'd9:    long_e = mk(8'hB6, 1, 0);
            5'd10:   long_e = mk(8'hDF, 6, 0);
            5'd11:   long_e = mk(8'hF3, 1, 0);
            5'd12:   long_e = mk(8'hB4, 3, 0);
            5'd13:   long_e = mk(8'hF7, 1, 0);
            5'd14:   long_e = mk(8'hB1, 3, 0);
            5'd15:   long_e = mk(8'hF2, 4, 0);
            5'd16:   long_e = mk(8'hC1, 4, 0);
            5'd17:   long_e = mk(8'h36, 1, 0);
            5'd18:   long_e = mk(8'h3A, 1, 0);
            5'd19:   long_e = mk(8'hE0, 16, 0);
            5'd20:   long_e = mk(8'hE1, 16, 0);
            5'd21:   long_e = mk(8'h35, 1, 0);
            default: long_e = mk(8'h00, 0, 0);
        endcase
    end

    assign entry    = use_short ? short_e : long_e;
    assign last_ent = use_short ? (ent == ENT_W'(N_SHORT - 1)) : (ent == ENT_W'(N_LONG - 1));

    // Parameter bytes follow a generated pattern; only the two pinned long entries are literal.
    always_comb begin
        if (!use_short && ent == '0) begin
            unique case (pidx)
                5'd0:    param = 8'hFF;
                5'd1:    param = 8'h98;
                default: param = 8'h06;
            endcase
        end else if (!use_short && ent == ENT_W'(N_LONG - 1)) begin
            param = 8'h00;
        end else begin
            param = entry.cmd ^ 8'(8'(pidx) * 8'h1D);
        end
    end
endmodule

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != '0) cnt <= cnt - W'(1);
    end

    assign expire = tick && (cnt == W'(1));
endmodule

// File: rtl/panel_boot_seq.sv
module panel_boot_seq
    import panel_boot_pkg::*;
#(
    parameter bit HAS_RST_PIN   = 1'b1,
    parameter int RST_HI_MS     = 100,
    parameter int RST_LO_MS     = 40,
    parameter int RST_SETTLE_MS = 100,
    parameter int ON_GAP_MS     = 100,
    parameter int TMR_W         = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic       panel_rst_n,
    output logic       bus_req,
    output logic       bus_rd,
    output logic [8:0] bus_word,
    input  logic       bus_ack,
    input  logic       bus_err,
    input  logic [7:0] bus_rdata
);
    boot_state_e      st, nx, after_ent;
    logic [ENT_W-1:0] ent;
    logic [CNT_W-1:0] pidx;
    logic             use_short, fail_q, pin_q;
    entry_t           cur;
    logic [7:0]       prm;
    logic             last_ent;
    logic             tmr_ld, tmr_exp, adv;
    logic [TMR_W-1:0] tmr_val;

    panel_cmd_rom u_rom (
        .use_short (use_short),
        .ent       (ent),
        .pidx      (pidx),
        .entry     (cur),
        .param     (prm),
        .last_ent  (last_ent)
    );

    panel_ms_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .tick     (ms_tick),
        .expire   (tmr_exp)
    );

    always_comb begin
        if (cur.dly != '0) after_ent = S_DLY;
        else if (last_ent) after_ent = S_ON;
        else               after_ent = S_CMD;
    end

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE: if (start) nx = HAS_RST_PIN ? S_RHI : S_ID;
            S_RHI:  if (tmr_exp) nx = S_RLO;
            S_RLO:  if (tmr_exp) nx = S_RWT;
            S_RWT:  if (tmr_exp) nx = S_ID;
            S_ID:   if (bus_ack) nx = bus_err ? S_IDLE : S_CMD;
            S_CMD:  if (bus_ack) nx = (bus_err || cur.cnt == '0) ? after_ent : S_PRM;
            S_PRM:  if (bus_ack && (bus_err || pidx == cur.cnt - CNT_W'(1))) nx = after_ent;
            S_DLY:  if (tmr_exp) nx = last_ent ? S_ON : S_CMD;
            S_ON:   if (bus_ack) nx = S_GAP;
            S_GAP:  if (tmr_exp) nx = S_OUT;
            S_OUT:  if (bus_ack) nx = S_DONE;
            S_DONE: nx = S_IDLE;
            default: nx = S_IDLE;
        endcase
    end

    // Every wait state loads the one shared countdown on entry.
    always_comb begin
        tmr_ld = (nx != st) && (nx inside {S_RHI, S_RLO, S_RWT, S_DLY, S_GAP});
        unique case (nx)
            S_RHI:   tmr_val = TMR_W'(RST_HI_MS);
            S_RLO:   tmr_val = TMR_W'(RST_LO_MS);
            S_RWT:   tmr_val = TMR_W'(RST_SETTLE_MS);
            S_DLY:   tmr_val = TMR_W'(cur.dly);
            S_GAP:   tmr_val = TMR_W'(ON_GAP_MS);
            default: tmr_val = '0;
        endcase
    end

    assign adv = (nx == S_CMD) && ((st == S_CMD) ? bus_ack : (st == S_PRM || st == S_DLY));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            ent       <= '0;
            pidx      <= '0;
            use_short <= 1'b0;
            fail_q    <= 1'b0;
            pin_q     <= 1'b0;
        end else begin
            st <= nx;
            if (st == S_IDLE)  ent <= '0;
            else if (adv)      ent <= ent + ENT_W'(1);
            if (st == S_CMD)                 pidx <= '0;
            else if (st == S_PRM && bus_ack) pidx <= pidx + CNT_W'(1);
            if (st == S_ID && bus_ack && !bus_err) use_short <= (bus_rdata == ID_SHORT);
            if (st == S_IDLE && start)                fail_q <= 1'b0;
            else if (st == S_ID && bus_ack && bus_err) fail_q <= 1'b1;
            if (nx == S_RLO)                      pin_q <= 1'b0;
            else if (nx == S_RHI || nx == S_RWT)  pin_q <= 1'b1;
        end
    end

    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        bus_req  = 1'b0;
        bus_rd   = 1'b0;
        bus_word = '0;
        unique case (st)
            S_IDLE: busy = 1'b0;
            S_DONE: begin busy = 1'b0; done = 1'b1; end
            S_ID:   begin bus_req = 1'b1; bus_rd = 1'b1; bus_word = {1'b0, CMD_RDID}; end
            S_CMD:  begin bus_req = 1'b1; bus_word = {1'b0, cur.cmd}; end
            S_PRM:  begin bus_req = 1'b1; bus_word = {1'b1, prm}; end
            S_ON:   begin bus_req = 1'b1; bus_word = {1'b0, CMD_DISP_ON}; end
            S_OUT:  begin bus_req = 1'b1; bus_word = {1'b0, CMD_WAKE}; end
            S_RHI, S_RLO, S_RWT, S_DLY, S_GAP: busy = 1'b1;
            default: busy = 1'b1;
        endcase
    end

    assign fail        = fail_q;
    assign panel_rst_n = HAS_RST_PIN ? pin_q : 1'b1;
endmodule

// File: rtl/panel_boot_seq_chk.sv
module panel_boot_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic       panel_rst_n,
    input logic       bus_req,
    input logic       bus_rd,
    input logic [8:0] bus_word,
    input logic       bus_ack
);
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_word) && $stable(bus_rd));

    assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !bus_req);

    assert_pin_drop_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_rst_n) |-> busy);

    assert_rdid_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> bus_req && bus_word == 9'h004);

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !done && start |=> busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fail_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !busy || !bus_req);

    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !start |=> fail);
endmodule

bind panel_boot_seq panel_boot_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .panel_rst_n (panel_rst_n),
    .bus_req     (bus_req),
    .bus_rd      (bus_rd),
    .bus_word    (bus_word),
    .bus_ack     (bus_ack)
);

// File: tb/panel_boot_seq_bench.sv
`timescale 1ns/1ps
module panel_boot_seq_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, ms_tick, start, start2;
    logic busy, done, fail, pin, req, rd;
    logic [8:0] word;
    logic ack, err;
    logic [7:0] rdata;
    logic busy2, done2, fail2, pin2, req2, rd2;
    logic [8:0] word2;

    panel_boot_seq u_panel_boot_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start),
        .busy(busy), .done(done), .fail(fail), .panel_rst_n(pin),
        .bus_req(req), .bus_rd(rd), .bus_word(word),
        .bus_ack(ack), .bus_err(err), .bus_rdata(rdata));

    panel_boot_seq #(.HAS_RST_PIN(1'b0)) u_panel_boot_seq_nopin (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .start(start2),
        .busy(busy2), .done(done2), .fail(fail2), .panel_rst_n(pin2),
        .bus_req(req2), .bus_rd(rd2), .bus_word(word2),
        .bus_ack(req2), .bus_err(1'b0), .bus_rdata(8'h80));

    int errs = 0, total = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Spec tables (R6, R7) and parameter rule (R5)
    function automatic int t_cmd(bit sh, int e);
        int s[8] = '{'h36, 'h3A, 'hB6, 'hC5, 'hE0, 'hE1, 'hB0, 'hB4};
        int l[22] = '{'hFF, 'hBA, 'hBC, 'hBD, 'hBE, 'hC7, 'hED, 'hC0, 'hFC, 'hB6, 'hDF,
                      'hF3, 'hB4, 'hF7, 'hB1, 'hF2, 'hC1, 'h36, 'h3A, 'hE0, 'hE1, 'h35};
        return sh ? s[e] : l[e];
    endfunction
    function automatic int t_cnt(bit sh, int e);
        int s[8] = '{1, 1, 4, 2, 16, 16, 1, 1};
        int l[22] = '{3, 1, 21, 8, 9, 1, 3, 3, 1, 1, 6, 1, 3, 1, 3, 4, 4, 1, 1, 16, 16, 1};
        return sh ? s[e] : l[e];
    endfunction
    function automatic int t_dly(bit sh, int e);
        if (sh && e == 5) return 20;
        if (sh && e == 7) return 100;
        return 0;
    endfunction
    function automatic int t_prm(bit sh, int e, int k);
        if (!sh && e == 0) return (k == 0) ? 'hFF : (k == 1) ? 'h98 : 'h06;
        if (!sh && e == 21) return 0;
        return (t_cmd(sh, e) ^ ((k * 'h1D) & 'hFF));
    endfunction

    int exp_word[256], exp_gap[256], exp_n;
    task automatic build_exp(input bit sh, input int ea);
        bit stop;
        exp_n = 0;
        exp_word[0] = 'h204; exp_gap[0] = 0; exp_n = 1;
        if (ea == 0) return;
        for (int e = 0; e < (sh ? 8 : 22); e++) begin
            stop = (exp_n == ea);
            exp_word[exp_n] = t_cmd(sh, e); exp_gap[exp_n] = 0; exp_n++;
            for (int k = 0; k < t_cnt(sh, e); k++) begin
                if (!stop) begin
                    stop = (exp_n == ea);
                    exp_word[exp_n] = 'h100 | t_prm(sh, e, k); exp_gap[exp_n] = 0; exp_n++;
                end
            end
            exp_gap[exp_n-1] = t_dly(sh, e);
        end
        exp_word[exp_n] = 'h29; exp_gap[exp_n] = 100; exp_n++;
        exp_word[exp_n] = 'h11; exp_gap[exp_n] = 0; exp_n++;
    endtask

    // Serial engine model and monitor
    int log_word[256], gap_cnt[256], log_n, t_hi, t_lo, done_n, hold_bad, ovl_bad;
    int err_at, wait_cnt, w0, pre2, done2_n;
    bit pend, seen2, pin2_low, tick_on;
    logic [7:0] id_val;

    always @(negedge clk) begin
        if (!rst_n) begin
            ack = 0; err = 0; pend = 0; ms_tick = 0;
        end else begin
            if (ack) begin
                ack = 0; err = 0;
            end else if (req) begin
                if (!pend) begin
                    pend = 1; wait_cnt = $urandom_range(0, 2); w0 = {rd, word};
                end
                if (wait_cnt == 0) begin
                    ack = 1;
                    err = (log_n == err_at);
                    if ({rd, word} != w0) hold_bad++;
                    if (log_n < 256) log_word[log_n] = {rd, word};
                    log_n++;
                    pend = 0;
                end else wait_cnt--;
            end
            rdata = id_val;
            ms_tick = tick_on && ($urandom_range(0, 2) == 0);
            if (ms_tick && busy && !req) begin
                if (log_n == 0) begin
                    if (pin) t_hi++; else t_lo++;
                end else if (log_n <= 256) gap_cnt[log_n-1]++;
            end
            if (done) done_n++;
            if (done && busy) ovl_bad++;
            if (ms_tick && busy2 && !req2 && !seen2) pre2++;
            if (req2) seen2 = 1;
            if (!pin2) pin2_low = 1;
            if (done2) done2_n++;
        end
    end

    task automatic run(input logic [7:0] id, input int ea, input bit poke);
        bit sh;
        @(posedge clk); #1;
        for (int i = 0; i < 256; i++) begin log_word[i] = 0; gap_cnt[i] = 0; end
        log_n = 0; t_hi = 0; t_lo = 0; done_n = 0; hold_bad = 0; ovl_bad = 0;
        id_val = id; err_at = ea;
        start = 1;
        @(posedge clk); #1;
        start = 0;
        chk(busy == 1, "R2 busy after start", busy, 1);
        chk(fail == 0, "R10 fail cleared by start", fail, 0);
        for (int c = 0; c < 20000; c++) begin
            if (done_n > 0 || !busy) break;
            start = (poke && c == 400);
            @(posedge clk); #1;
        end
        start = 0;
        repeat (3) @(posedge clk); #1;
        sh = (id == 8'h80);
        build_exp(sh, ea);
        chk(log_n == exp_n, (ea == 0) ? "R10 word count" : (ea > 0 ? "R8 word count" : "R6 word count"), log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_word[i] == exp_word[i], (i == 0) ? "R4 id read word" :
                ((exp_word[i] & 'h100) != 0 ? "R5 param word" : "R6 command word"),
                log_word[i], exp_word[i]);
            if (i > 0)
                chk(gap_cnt[i] == exp_gap[i], (exp_word[i] == 'h29) ? "R9 on gap" : "R7 post delay",
                    gap_cnt[i], exp_gap[i]);
        end
        chk(t_hi == 200, "R3 high ticks", t_hi, 200);
        chk(t_lo == 40, "R3 low ticks", t_lo, 40);
        chk(hold_bad == 0, "R13 word held", hold_bad, 0);
        chk(busy == 0, "R11 busy low at end", busy, 0);
        if (ea == 0) begin
            chk(fail == 1, "R10 fail set", fail, 1);
            chk(done_n == 0, "R10 no done", done_n, 0);
        end else begin
            chk(fail == 0, "R10 fail clear", fail, 0);
            chk(done_n == 1, "R11 one done", done_n, 1);
            chk(ovl_bad == 0, "R11 done with busy low", ovl_bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; start = 0; start2 = 0; tick_on = 1; id_val = 8'h80; err_at = -1;
        log_n = 0; pre2 = 0; done2_n = 0; seen2 = 0; pin2_low = 0;
        repeat (3) @(posedge clk); #1;
        chk({busy, done, fail, req, pin} == 5'b0, "R1 reset outputs", {busy, done, fail, req, pin}, 0);
        rst_n = 1;
        repeat (3) @(posedge clk); #1;
        chk({busy, done, fail, req, pin} == 5'b0, "R1 idle outputs", {busy, done, fail, req, pin}, 0);
        run(8'h80, -1, 0);
        run(8'h12, -1, 1);
        run(8'h80, 0, 0);
        run(8'h80, 5, 0);
        run(8'h33, 7, 0);
        run(8'h80, 60, 0);
        for (int r = 0; r < 3; r++) begin
            logic [7:0] rid;
            rid = ($urandom_range(0, 1) == 1) ? 8'h80 : 8'($urandom_range(0, 255));
            run(rid, $urandom_range(1, 120), 0);
        end
        @(posedge clk); #1;
        start2 = 1;
        @(posedge clk); #1;
        start2 = 0;
        for (int c = 0; c < 20000; c++) begin
            if (done2_n > 0) break;
            @(posedge clk); #1;
        end
        chk(pre2 == 0, "R12 no reset waits", pre2, 0);
        chk(pin2_low == 0, "R12 pin stays high", pin2_low, 0);
        chk(done2_n == 1, "R12 completes", done2_n, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end
endmodule